// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Controller

This block joins two eight-input priority interrupt controllers into one sixteen-line request source for a processor. A primary unit serves system lines 0 to 7. A secondary unit serves lines 8 to 15, and its request output is wired internally to primary input 2. Each line latches a request on a rising edge or follows its level, chosen one line at a time. Requests pass through a mask and a fixed nested priority, and the block raises one interrupt output towards the processor.

When the processor acknowledges, the block marks the winning line as in service and returns an 8-bit vector one cycle later. The upper five bits of the vector come from a programmable base, and the low three bits carry the input index. A small write port sets the two masks and the two vector bases, and it sends end-of-interrupt commands to either unit. Line 8 is active low by default, for a real-time-clock style source. Line 2 carries no external source.

Top module: `irqc_top`

## Requirements
- R1: After reset, int_out and vec_valid are low, both masks are clear, the primary vector base is 0x08 and the secondary base is 0x70.
- R2: A line in edge mode (level_sel bit 0) latches a request on a rising edge of its active level. Acknowledge clears the latched request, so a line that stays high after acknowledge and end-of-interrupt does not request again.
- R3: A line in level mode (level_sel bit 1) requests only while it is held active. Releasing it before acknowledge withdraws the request, and a line still held after end-of-interrupt requests again.
- R4: While a line's mask bit is 1 it does not drive int_out. An edge that arrives while the line is masked stays latched and is served after the line is unmasked.
- R5: Priority is fixed. Within each unit, input 0 is highest and input 7 is lowest. The whole secondary group ranks at primary input 2, so line 1 beats line 9 and line 9 beats line 3.
- R6: One cycle after an int_ack cycle, vec_valid pulses for one cycle and vec_out equals {base[7:3], index}. The base is the secondary base when the secondary unit wins. Write address 4 sets the primary base and address 5 sets the secondary base.
- R7: A request raises int_out only if its priority is strictly higher than every in-service line of its unit. Equal and lower priorities wait.
- R8: Writing to command address 2 (primary) or 3 (secondary) with bit 5 set sends an end-of-interrupt. If bit 6 is clear, it clears the highest-priority in-service bit. If bit 6 is set, it clears the bit named by bits 2:0. A command byte with bit 5 clear has no effect.
- R9: A served secondary line keeps primary input 2 in service until the primary unit receives an end-of-interrupt. It also keeps its own secondary bit in service until the secondary unit receives one.
- R10: An acknowledge with no request above the in-service level returns {primary base[7:3], 7} and sets no in-service bit.
- R11: irq_in[2] has no effect.
- R12: Line 8 is active low by default. Driving irq_in[8] from 1 to 0 raises a request.
- R13: When an acknowledge and an end-of-interrupt to the same unit fall in the same cycle, the end-of-interrupt acts on the in-service bits held before that cycle, and the acknowledged line stays in service.
- R14: Write address 0 sets the primary mask and address 1 sets the secondary mask. Mask bit i belongs to input i of that unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 16 | Request lines 0 to 15. Bit 2 is unused. Polarity is set by a parameter. |
| level_sel | input | 16 | Sensitivity per line: 1 for level, 0 for edge |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 3 | Write address: 0/1 masks, 2/3 commands, 4/5 vector bases |
| reg_wdata | input | 8 | Write data |
| int_out | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | Acknowledge, one cycle |
| vec_valid | output | 1 | Vector present, one cycle after int_ack |
| vec_out | output | 8 | Returned vector |

## Verification
Acknowledge and end-of-interrupt can land on the same clock edge. The bench provokes this by driving int_ack and a non-specific command write in one cycle, while one line is in service and a higher one is pending. It then judges the outcome from later behaviour. The vector must name the new line. A lower line must stay blocked, which shows the new line is in service. After one more end-of-interrupt, that lower line must come through, which shows the older in-service bit was the one cleared.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int CTRL_W  = 8;
    localparam int IDX_W   = $clog2(CTRL_W);
    localparam int LINES   = 2 * CTRL_W;
    localparam int CASC_IX = 2;

    typedef logic [CTRL_W-1:0] vec_t;
    typedef logic [IDX_W-1:0]  idx_t;

    // lowest set index = highest priority; all-zero input yields the bottom index
    function automatic idx_t low_idx(input vec_t v);
        idx_t r;
        r = idx_t'(CTRL_W - 1);
        for (int i = CTRL_W - 1; i >= 0; i--) begin
            if (v[i]) r = idx_t'(i);
        end
        return r;
    endfunction

    function automatic vec_t one_hot(input idx_t i);
        vec_t r;
        r = '0;
        r[i] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter logic [7:0] MBASE_RST = 8'h08,
    parameter logic [7:0] SBASE_RST = 8'h70
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output vec_t       mask_m,
    output vec_t       mask_s,
    output logic [7:0] base_m,
    output logic [7:0] base_s,
    output logic       eoi_ns_m,
    output logic       eoi_sp_m,
    output logic       eoi_ns_s,
    output logic       eoi_sp_s,
    output idx_t       eoi_lvl
);
    typedef struct packed {
        vec_t       mask_m;
        vec_t       mask_s;
        logic [7:0] base_m;
        logic [7:0] base_s;
    } regs_t;

    regs_t r_q, r_d;
    logic  cmd_m, cmd_s;

    always_comb begin
        r_d = r_q;
        if (wr) begin
            case (addr)
                3'd0:    r_d.mask_m = wdata[CTRL_W-1:0];
                3'd1:    r_d.mask_s = wdata[CTRL_W-1:0];
                3'd4:    r_d.base_m = wdata;
                3'd5:    r_d.base_s = wdata;
                default: ;
            endcase
        end
        cmd_m    = wr && (addr == 3'd2) && wdata[5];
        cmd_s    = wr && (addr == 3'd3) && wdata[5];
        eoi_ns_m = cmd_m && !wdata[6];
        eoi_sp_m = cmd_m &&  wdata[6];
        eoi_ns_s = cmd_s && !wdata[6];
        eoi_sp_s = cmd_s &&  wdata[6];
        eoi_lvl  = wdata[IDX_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{mask_m: '0, mask_s: '0, base_m: MBASE_RST, base_s: SBASE_RST};
        end else begin
            r_q <= r_d;
        end
    end

    assign mask_m = r_q.mask_m;
    assign mask_s = r_q.mask_s;
    assign base_m = r_q.base_m;
    assign base_s = r_q.base_s;
endmodule

// File: rtl/irqc_unit.sv
module irqc_unit
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  vec_t req_raw,
    input  vec_t level,
    input  vec_t mask,
    input  logic take,
    input  logic eoi_ns,
    input  logic eoi_sp,
    input  idx_t eoi_lvl,
    output logic req_out,
    output idx_t win_idx
);
    typedef struct packed {
        vec_t irr;
        vec_t isr;
        vec_t prev;
    } unit_t;

    unit_t s_q, s_d;
    vec_t  rise, pend, set_v, clr_v;
    idx_t  isr_hi;
    logic  has_pend, has_isr;

    always_comb begin
        rise     = req_raw & ~s_q.prev;
        pend     = ((s_q.irr & ~level) | (req_raw & level)) & ~mask;
        has_pend = |pend;
        has_isr  = |s_q.isr;
        win_idx  = low_idx(pend);
        isr_hi   = low_idx(s_q.isr);
        req_out  = has_pend && (!has_isr || (win_idx < isr_hi));

        set_v = (take && req_out) ? one_hot(win_idx) : '0;
        if (eoi_sp)                 clr_v = one_hot(eoi_lvl);
        else if (eoi_ns && has_isr) clr_v = one_hot(isr_hi);
        else                        clr_v = '0;

        s_d.prev = req_raw;
        s_d.irr  = ((s_q.irr & ~set_v) | rise) & ~level;
        s_d.isr  = (s_q.isr & ~clr_v) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_out) |=> s_q.isr[$past(win_idx)]) else $error("ack lost"); // R7

    AST_ACK_CLEARS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_out && !level[win_idx] && !rise[win_idx]) |=> !s_q.irr[$past(win_idx)])
        else $error("edge request kept"); // R2

    AST_SPEC_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_sp && !(take && req_out)) |=> !s_q.isr[$past(eoi_lvl)])
        else $error("specific eoi ignored"); // R8
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter logic [LINES-1:0] INV_MASK  = 16'h0100,
    parameter logic [7:0]       MBASE_RST = 8'h08,
    parameter logic [7:0]       SBASE_RST = 8'h70
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] irq_in,
    input  logic [LINES-1:0] level_sel,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic             int_out,
    input  logic             int_ack,
    output logic             vec_valid,
    output logic [7:0]       vec_out
);
    typedef struct packed {
        logic       irq;
        logic       vld;
        logic [7:0] vec;
    } out_t;

    out_t             o_q, o_d;
    logic [LINES-1:0] act;
    vec_t             m_raw, m_lvl, mask_m, mask_s;
    logic [7:0]       base_m, base_s;
    logic             eoi_ns_m, eoi_sp_m, eoi_ns_s, eoi_sp_s;
    idx_t             eoi_lvl, m_win, s_win;
    logic             m_req, s_req, s_take;
    logic [7:0]       vec_sel;

    irqc_regs #(.MBASE_RST(MBASE_RST), .SBASE_RST(SBASE_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .mask_m(mask_m), .mask_s(mask_s), .base_m(base_m), .base_s(base_s),
        .eoi_ns_m(eoi_ns_m), .eoi_sp_m(eoi_sp_m), .eoi_ns_s(eoi_ns_s),
        .eoi_sp_s(eoi_sp_s), .eoi_lvl(eoi_lvl)
    );

    always_comb begin
        act   = irq_in ^ INV_MASK;
        m_raw = act[CTRL_W-1:0];
        m_raw[CASC_IX] = s_req;          // cascade replaces the external line
        m_lvl = level_sel[CTRL_W-1:0];
        m_lvl[CASC_IX] = 1'b1;           // cascade input follows the secondary request
    end

    irqc_unit u_slave (
        .clk(clk), .rst_n(rst_n), .req_raw(act[LINES-1:CTRL_W]),
        .level(level_sel[LINES-1:CTRL_W]), .mask(mask_s), .take(s_take),
        .eoi_ns(eoi_ns_s), .eoi_sp(eoi_sp_s), .eoi_lvl(eoi_lvl),
        .req_out(s_req), .win_idx(s_win)
    );

    irqc_unit u_master (
        .clk(clk), .rst_n(rst_n), .req_raw(m_raw), .level(m_lvl), .mask(mask_m),
        .take(int_ack), .eoi_ns(eoi_ns_m), .eoi_sp(eoi_sp_m), .eoi_lvl(eoi_lvl),
        .req_out(m_req), .win_idx(m_win)
    );

    always_comb begin
        s_take = int_ack && m_req && (m_win == idx_t'(CASC_IX));
        if (!m_req)                          vec_sel = {base_m[7:IDX_W], idx_t'(CTRL_W-1)};
        else if (m_win != idx_t'(CASC_IX))   vec_sel = {base_m[7:IDX_W], m_win};
        else if (s_req)                      vec_sel = {base_s[7:IDX_W], s_win};
        else                                 vec_sel = {base_s[7:IDX_W], idx_t'(CTRL_W-1)};
        o_d.irq = m_req;
        o_d.vld = int_ack;
        o_d.vec = int_ack ? vec_sel : o_q.vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign int_out   = o_q.irq;
    assign vec_valid = o_q.vld;
    assign vec_out   = o_q.vec;

    AST_VEC_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |=> vec_valid) else $error("no vector"); // R6

    AST_VEC_ONLY_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !int_ack |=> !vec_valid) else $error("stray vector"); // R6

    AST_SPURIOUS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && !m_req) |=> (vec_out[IDX_W-1:0] == idx_t'(CTRL_W-1)))
        else $error("spurious vector wrong"); // R10
endmodule

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_in = 16'h0100;
    logic [15:0] level_sel = 16'h0000;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [7:0]  reg_wdata = 8'h00;
    logic        int_ack = 1'b0;
    logic        int_out, vec_valid;
    logic [7:0]  vec_out;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [7:0]  exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    irqc_top u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level_sel(level_sel),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .int_out(int_out), .int_ack(int_ack), .vec_valid(vec_valid), .vec_out(vec_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic int_is(input string req, input logic exp);
        repeat (3) @(negedge clk);
        check(req, {7'd0, int_out}, {7'd0, exp});
    endtask

    // driver: queue the expected vector, then pulse acknowledge
    task automatic ack(input string req, input logic [7:0] exp, input logic with_eoi);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(req);
        int_ack = 1'b1;
        if (with_eoi) begin
            reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 8'h20;
        end
        @(negedge clk);
        int_ack = 1'b0;
        reg_wr  = 1'b0;
        @(negedge clk);
    endtask

    task automatic raise(input int line);
        @(negedge clk);
        irq_in[line] = 1'b1;
    endtask

    // monitor: compare each produced vector against the queue head
    always @(negedge clk) begin
        if (rst_n && vec_valid) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R6 unexpected vector actual=%h expected=none", vec_out);
            end else begin
                check(tag_q.pop_front(), vec_out, exp_q.pop_front());
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected<=50000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 int", {7'd0, int_out}, 8'd0);
        check("R1 vld", {7'd0, vec_valid}, 8'd0);

        // R10 spurious then line 7 still serviceable
        ack("R10 spurious", 8'h0F, 1'b0);
        raise(7);
        int_is("R10 no isr7 held", 1'b1);
        ack("R10 real7", 8'h0F, 1'b0);
        wr(3'd2, 8'h20);
        irq_in[7] = 1'b0;

        // R2 edge held after service
        raise(3);
        int_is("R2 edge", 1'b1);
        ack("R2 vec", 8'h0B, 1'b0);
        wr(3'd2, 8'h20);
        int_is("R2 no rerequest", 1'b0);
        irq_in[3] = 1'b0;

        // R3 level mode
        level_sel[4] = 1'b1;
        raise(4);
        int_is("R3 level on", 1'b1);
        irq_in[4] = 1'b0;
        int_is("R3 withdrawn", 1'b0);
        raise(4);
        ack("R3 vec", 8'h0C, 1'b0);
        int_is("R7 equal blocked", 1'b0);
        wr(3'd2, 8'h20);
        int_is("R3 held again", 1'b1);
        irq_in[4] = 1'b0;
        int_is("R3 released", 1'b0);
        level_sel[4] = 1'b0;

        // R4 / R14 mask
        wr(3'd0, 8'h20);
        raise(5);
        @(negedge clk); irq_in[5] = 1'b0;
        int_is("R4 masked", 1'b0);
        wr(3'd0, 8'h00);
        int_is("R4 unmasked latched", 1'b1);
        ack("R14 vec", 8'h0D, 1'b0);
        wr(3'd2, 8'h20);

        // R5 priority and R9 cascade
        @(negedge clk); irq_in[1] = 1'b1; irq_in[3] = 1'b1; irq_in[9] = 1'b1;
        int_is("R5 pending", 1'b1);
        ack("R5 line1 first", 8'h09, 1'b0);
        int_is("R7 lower blocked", 1'b0);
        wr(3'd2, 8'h20);
        int_is("R5 slave next", 1'b1);
        ack("R6 slave vec", 8'h71, 1'b0);
        int_is("R5 line3 below slave", 1'b0);
        wr(3'd3, 8'h20);
        int_is("R9 master ir2 held", 1'b0);
        wr(3'd2, 8'h20);
        int_is("R5 line3 last", 1'b1);
        ack("R5 vec3", 8'h0B, 1'b0);
        wr(3'd2, 8'h20);
        irq_in[1] = 1'b0; irq_in[3] = 1'b0; irq_in[9] = 1'b0;

        raise(10);
        ack("R9 vec10", 8'h72, 1'b0);
        wr(3'd2, 8'h20);
        raise(11);
        int_is("R9 slave isr held", 1'b0);
        wr(3'd3, 8'h20);
        int_is("R9 after slave eoi", 1'b1);
        ack("R9 vec11", 8'h73, 1'b0);
        wr(3'd3, 8'h20);
        wr(3'd2, 8'h20);
        irq_in[10] = 1'b0; irq_in[11] = 1'b0;

        // R8 specific and ignored commands
        raise(6);
        ack("R8 vec6", 8'h0E, 1'b0);
        raise(3);
        int_is("R7 higher nests", 1'b1);
        ack("R8 vec3", 8'h0B, 1'b0);
        wr(3'd2, 8'h66);
        wr(3'd2, 8'h00);
        raise(4);
        int_is("R8 isr3 kept", 1'b0);
        wr(3'd2, 8'h20);
        int_is("R8 ns cleared 3", 1'b1);
        ack("R8 vec4", 8'h0C, 1'b0);
        wr(3'd2, 8'h20);
        raise(7);
        int_is("R8 specific cleared 6", 1'b1);
        ack("R8 vec7", 8'h0F, 1'b0);
        wr(3'd2, 8'h20);
        irq_in[3] = 1'b0; irq_in[4] = 1'b0; irq_in[6] = 1'b0; irq_in[7] = 1'b0;

        // R11 line 2 ignored
        raise(2);
        int_is("R11 line2", 1'b0);
        irq_in[2] = 1'b0;

        // R12 active-low line 8
        @(negedge clk); irq_in[8] = 1'b0;
        int_is("R12 low active", 1'b1);
        ack("R12 vec", 8'h70, 1'b0);
        wr(3'd3, 8'h20);
        wr(3'd2, 8'h20);
        irq_in[8] = 1'b1;

        // R13 ack and eoi together
        raise(5);
        ack("R13 vec5", 8'h0D, 1'b0);
        raise(1);
        int_is("R13 nest", 1'b1);
        ack("R13 vec1", 8'h09, 1'b1);
        raise(6);
        int_is("R13 isr1 set", 1'b0);
        wr(3'd2, 8'h20);
        int_is("R13 isr5 was cleared", 1'b1);
        ack("R13 vec6", 8'h0E, 1'b0);
        wr(3'd2, 8'h20);
        irq_in[1] = 1'b0; irq_in[5] = 1'b0; irq_in[6] = 1'b0;

        // R6 base change
        wr(3'd4, 8'h20);
        raise(3);
        ack("R6 base", 8'h23, 1'b0);
        wr(3'd2, 8'h20);
        irq_in[3] = 1'b0;
        wr(3'd4, 8'h08);

        repeat (4) @(negedge clk);
        check("R6 all vectors seen", 8'(exp_q.size()), 8'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule